// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 48-bit virtual address into a physical address. It reads a chain of 64-bit translation descriptors from memory, using a 4KB granule and up to four lookup levels. A caller hands over the virtual address, the address of the top-level table and a hierarchical-disable flag through a valid/ready handshake. The walker then issues one descriptor read at a time on a simple request/response memory port. It decodes each descriptor that comes back, and for each one it either follows the pointer to the next table, stops on a block or page mapping, or stops with a fault.

Table descriptors carry restrictions that apply to every level below them. These are the non-secure flag, read-only, no-user-access, user execute-never and privileged execute-never. The walker merges them along the path and applies them to the attributes of the final mapping. When the walk finishes, the walker gives a one-cycle done pulse. With it come either the physical address and the merged attributes, or the fault type and the level at which the walk stopped.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low from the next cycle until the done pulse.
- R2: Each descriptor read is a single-cycle `mem_req_valid` pulse. The read address is {table[47:12], index, 3'b000}. The index is VA[47:39], VA[38:30], VA[29:21] or VA[20:12] for levels 0 to 3, and the level-0 table comes from `req_base[47:12]`.
- R3: At levels 0 to 2, a descriptor with bits[1:0]=2'b11 is a table pointer. The next read then uses descriptor bits[47:12] as the table address.
- R4: A descriptor with bit 0 clear ends the walk with `walk_fault`=2'b01 (translation) at that level. At level 3, bits[1:0]=2'b01 is handled the same way.
- R5: A block descriptor (bits[1:0]=2'b01) at level 0 ends the walk with a translation fault at level 0.
- R6: The output address is {desc[47:30], VA[29:0]} for a level-1 block, {desc[47:21], VA[20:0]} for a level-2 block and {desc[47:12], VA[11:0]} for a level-3 page (bits[1:0]=2'b11).
- R7: The leaf attributes are taken from descriptor bits 4:2 (memory attribute index), 5 (non-secure), 7:6 (access permission: bit 7 read-only, bit 6 user access), 9:8 (shareability), 11 (not-global), 52 (contiguous hint), 53 (privileged execute-never) and 54 (user execute-never).
- R8: A leaf whose access flag (bit 10) is 0 ends the walk with `walk_fault`=2'b10 at that level.
- R9: If bit 62 is set in any table descriptor on the path, the output permission bit 1 is forced to 1. If bit 61 is set on the path, output permission bit 0 is forced to 0.
- R10: If bit 60 is set in a table descriptor on the path, `walk_uxn` is forced to 1. Bit 59 forces `walk_pxn` to 1, and bit 63 forces `walk_ns` to 1.
- R11: When `req_hier_dis` is 1 for a walk, table bits 62:59 have no effect on the result. Table bit 63 still applies.
- R12: `walk_done` is a one-cycle pulse in the cycle after the final descriptor response. On a fault, `walk_pa` and all attribute outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 48 | Virtual address to translate |
| req_base | input | 48 | Level-0 table address (bits 11:0 unused) |
| req_hier_dis | input | 1 | Ignore permission and execute limits from tables |
| mem_req_valid | output | 1 | Descriptor read strobe |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor returned by memory |
| walk_done | output | 1 | Walk finished (one cycle) |
| walk_fault | output | 2 | 00 none, 01 translation, 10 access flag |
| walk_level | output | 2 | Level of the final or faulting descriptor |
| walk_pa | output | 48 | Physical address |
| walk_attr_idx | output | 3 | Memory attribute index |
| walk_ns | output | 1 | Non-secure output |
| walk_ap | output | 2 | Access permission after limits |
| walk_sh | output | 2 | Shareability |
| walk_ng | output | 1 | Not-global |
| walk_contig | output | 1 | Contiguous hint |
| walk_pxn | output | 1 | Privileged execute-never after limits |
| walk_uxn | output | 1 | User execute-never after limits |

## Verification
The hardest case to reach is a restriction that is set high in the tree and must still act on a leaf three reads later, or a restriction that must be dropped because hierarchical disable was set for that walk. The bench builds sparse descriptor trees in a behavioural memory with limits set at different levels. It runs the same tree once with the disable flag and once without, so only the merge logic tells the two results apart. Memory latency changes from walk to walk so that decoding is exercised with responses arriving at different offsets from the read strobe.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_XLATE  = 2'd1,
    FLT_ACCESS = 2'd2
  } walk_flt_e;

  // restrictions inherited from table descriptors
  typedef struct packed {
    logic ns;
    logic ap_ro;
    logic ap_noel0;
    logic xn;
    logic pxn;
  } tbl_lim_t;

  typedef struct packed {
    logic [2:0] idx;
    logic       ns;
    logic [1:0] ap;
    logic [1:0] sh;
    logic       ng;
    logic       contig;
    logic       pxn;
    logic       uxn;
  } leaf_attr_t;

endpackage

// File: rtl/pt_idx_sel.sv
module pt_idx_sel #(
  parameter int AW         = 48,
  parameter int GRAN_SHIFT = 12,
  parameter int IDX_W      = 9,
  parameter int LVL        = 4,
  localparam int LVL_W     = $clog2(LVL)
) (
  input  logic [AW-1:0]    va,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_tbl [LVL];

  for (genvar g = 0; g < LVL; g++) begin : g_lvl
    assign idx_tbl[g] = va[GRAN_SHIFT + (LVL-1-g)*IDX_W +: IDX_W];
  end

  assign idx = idx_tbl[level];

endmodule

// File: rtl/pt_desc_dec.sv
module pt_desc_dec
  import pt_walker_pkg::*;
#(
  parameter int AW         = 48,
  parameter int DW         = 64,
  parameter int GRAN_SHIFT = 12,
  parameter int IDX_W      = 9,
  parameter int LVL        = 4,
  localparam int LVL_W     = $clog2(LVL),
  localparam int TBL_W     = AW - GRAN_SHIFT
) (
  input  logic [DW-1:0]    desc,
  input  logic [LVL_W-1:0] level,
  input  logic [AW-1:0]    va,
  input  logic             hier_dis,
  output logic             go_down,
  output logic             flt_xlate,
  output logic             flt_af,
  output logic [TBL_W-1:0] nxt_tbl,
  output logic [AW-1:0]    leaf_pa,
  output leaf_attr_t       raw_attr,
  output tbl_lim_t         lim
);

  logic          last_lvl;
  logic          leaf_ok;
  logic [AW-1:0] pa_lvl [LVL];
  logic          unused_bits;

  assign last_lvl = (level == LVL_W'(LVL-1));
  assign go_down  = desc[0] && desc[1] && !last_lvl;
  // leaf: page at the last level, block at middle levels, never at level 0
  assign leaf_ok  = desc[0] && (last_lvl ? desc[1]
                                         : (!desc[1] && (level != '0)));
  assign flt_xlate = !go_down && !leaf_ok;
  assign flt_af    = leaf_ok && !desc[10];
  assign nxt_tbl   = desc[AW-1:GRAN_SHIFT];

  for (genvar g = 0; g < LVL; g++) begin : g_pa
    localparam int SH = GRAN_SHIFT + (LVL-1-g)*IDX_W;
    assign pa_lvl[g] = {desc[AW-1:SH], va[SH-1:0]};
  end
  assign leaf_pa = pa_lvl[level];

  assign raw_attr.idx    = desc[4:2];
  assign raw_attr.ns     = desc[5];
  assign raw_attr.ap     = desc[7:6];
  assign raw_attr.sh     = desc[9:8];
  assign raw_attr.ng     = desc[11];
  assign raw_attr.contig = desc[52];
  assign raw_attr.pxn    = desc[53];
  assign raw_attr.uxn    = desc[54];

  assign lim.ns       = desc[63];
  assign lim.ap_ro    = desc[62] & ~hier_dis;
  assign lim.ap_noel0 = desc[61] & ~hier_dis;
  assign lim.xn       = desc[60] & ~hier_dis;
  assign lim.pxn      = desc[59] & ~hier_dis;

  assign unused_bits = ^{desc[58:55], desc[51:AW], va[AW-1:GRAN_SHIFT+(LVL-1)*IDX_W]};

endmodule

// File: rtl/pt_leaf_merge.sv
module pt_leaf_merge
  import pt_walker_pkg::*;
(
  input  leaf_attr_t raw_attr,
  input  tbl_lim_t   acc,
  output leaf_attr_t out_attr
);

  always_comb begin
    out_attr        = raw_attr;
    out_attr.ns     = raw_attr.ns | acc.ns;
    out_attr.ap[1]  = raw_attr.ap[1] | acc.ap_ro;
    out_attr.ap[0]  = raw_attr.ap[0] & ~acc.ap_noel0;
    out_attr.uxn    = raw_attr.uxn | acc.xn;
    out_attr.pxn    = raw_attr.pxn | acc.pxn;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int AW         = 48,
  parameter int DW         = 64,
  parameter int IDX_W      = 9,
  parameter int LVL        = 4,
  localparam int DESC_SH   = $clog2(DW/8),
  localparam int GRAN_SHIFT = IDX_W + DESC_SH,
  localparam int LVL_W     = $clog2(LVL),
  localparam int TBL_W     = AW - GRAN_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_va,
  input  logic [AW-1:0]    req_base,
  input  logic             req_hier_dis,
  output logic             mem_req_valid,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             walk_done,
  output logic [1:0]       walk_fault,
  output logic [LVL_W-1:0] walk_level,
  output logic [AW-1:0]    walk_pa,
  output logic [2:0]       walk_attr_idx,
  output logic             walk_ns,
  output logic [1:0]       walk_ap,
  output logic [1:0]       walk_sh,
  output logic             walk_ng,
  output logic             walk_contig,
  output logic             walk_pxn,
  output logic             walk_uxn
);

  walk_st_e         st_q, st_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [AW-1:0]    va_q, va_d;
  logic [TBL_W-1:0] tbl_q, tbl_d;
  logic             hd_q, hd_d;
  tbl_lim_t         acc_q, acc_d;
  logic             done_q, done_d;
  walk_flt_e        fk_q, fk_d;
  logic [LVL_W-1:0] fl_q, fl_d;
  logic [AW-1:0]    pa_q, pa_d;
  leaf_attr_t       attr_q, attr_d;

  logic [IDX_W-1:0] idx;
  logic             go_down, flt_xlate, flt_af;
  logic [TBL_W-1:0] nxt_tbl;
  logic [AW-1:0]    leaf_pa;
  leaf_attr_t       raw_attr, merged;
  tbl_lim_t         lim;
  logic             unused_base;

  pt_idx_sel #(.AW(AW), .GRAN_SHIFT(GRAN_SHIFT), .IDX_W(IDX_W), .LVL(LVL)) u_idx (
    .va    (va_q),
    .level (lvl_q),
    .idx   (idx)
  );

  pt_desc_dec #(.AW(AW), .DW(DW), .GRAN_SHIFT(GRAN_SHIFT), .IDX_W(IDX_W), .LVL(LVL)) u_dec (
    .desc      (mem_rsp_data),
    .level     (lvl_q),
    .va        (va_q),
    .hier_dis  (hd_q),
    .go_down   (go_down),
    .flt_xlate (flt_xlate),
    .flt_af    (flt_af),
    .nxt_tbl   (nxt_tbl),
    .leaf_pa   (leaf_pa),
    .raw_attr  (raw_attr),
    .lim       (lim)
  );

  pt_leaf_merge u_merge (
    .raw_attr (raw_attr),
    .acc      (acc_q),
    .out_attr (merged)
  );

  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    va_d   = va_q;
    tbl_d  = tbl_q;
    hd_d   = hd_q;
    acc_d  = acc_q;
    done_d = 1'b0;
    fk_d   = fk_q;
    fl_d   = fl_q;
    pa_d   = pa_q;
    attr_d = attr_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d  = ST_ISSUE;
          lvl_d = '0;
          va_d  = req_va;
          tbl_d = req_base[AW-1:GRAN_SHIFT];
          hd_d  = req_hier_dis;
          acc_d = '0;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (go_down) begin
            st_d  = ST_ISSUE;
            lvl_d = lvl_q + LVL_W'(1);
            tbl_d = nxt_tbl;
            acc_d = tbl_lim_t'(acc_q | lim);
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            fl_d   = lvl_q;
            if (flt_xlate || flt_af) begin
              fk_d   = flt_xlate ? FLT_XLATE : FLT_ACCESS;
              pa_d   = '0;
              attr_d = '0;
            end else begin
              fk_d   = FLT_NONE;
              pa_d   = leaf_pa;
              attr_d = merged;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lvl_q  <= '0;
      va_q   <= '0;
      tbl_q  <= '0;
      hd_q   <= 1'b0;
      acc_q  <= '0;
      done_q <= 1'b0;
      fk_q   <= FLT_NONE;
      fl_q   <= '0;
      pa_q   <= '0;
      attr_q <= '0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      va_q   <= va_d;
      tbl_q  <= tbl_d;
      hd_q   <= hd_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      fk_q   <= fk_d;
      fl_q   <= fl_d;
      pa_q   <= pa_d;
      attr_q <= attr_d;
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign mem_req_addr  = {tbl_q, idx, {DESC_SH{1'b0}}};
  assign walk_done     = done_q;
  assign walk_fault    = fk_q;
  assign walk_level    = fl_q;
  assign walk_pa       = pa_q;
  assign walk_attr_idx = attr_q.idx;
  assign walk_ns       = attr_q.ns;
  assign walk_ap       = attr_q.ap;
  assign walk_sh       = attr_q.sh;
  assign walk_ng       = attr_q.ng;
  assign walk_contig   = attr_q.contig;
  assign walk_pxn      = attr_q.pxn;
  assign walk_uxn      = attr_q.uxn;
  assign unused_base   = ^req_base[GRAN_SHIFT-1:0];

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_rsp_valid,
  input logic          walk_done,
  input logic [1:0]    walk_fault,
  input logic [1:0]    walk_level,
  input logic [AW-1:0] walk_pa
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R2

  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R1

  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> $past(mem_rsp_valid)); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done); // R12

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault != 2'b00) |-> (walk_pa == '0)); // R4

  AST_NO_L0_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault == 2'b00) |-> (walk_level != 2'd0)); // R5

endmodule

bind pt_walker pt_walker_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .walk_done     (walk_done),
  .walk_fault    (walk_fault),
  .walk_level    (walk_level),
  .walk_pa       (walk_pa)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

  localparam logic [47:0] T0 = 48'h0001_0000;
  localparam logic [47:0] T1 = 48'h0002_0000;
  localparam logic [47:0] T2 = 48'h0003_0000;
  localparam logic [47:0] T3 = 48'h0004_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_hier_dis;
  logic [47:0] req_va, req_base, mem_req_addr, walk_pa;
  logic        mem_req_valid, mem_rsp_valid, walk_done;
  logic [63:0] mem_rsp_data;
  logic [1:0]  walk_fault, walk_level, walk_ap, walk_sh;
  logic [2:0]  walk_attr_idx;
  logic        walk_ns, walk_ng, walk_contig, walk_pxn, walk_uxn;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_base(req_base), .req_hier_dis(req_hier_dis),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .walk_done(walk_done), .walk_fault(walk_fault), .walk_level(walk_level),
    .walk_pa(walk_pa), .walk_attr_idx(walk_attr_idx), .walk_ns(walk_ns),
    .walk_ap(walk_ap), .walk_sh(walk_sh), .walk_ng(walk_ng),
    .walk_contig(walk_contig), .walk_pxn(walk_pxn), .walk_uxn(walk_uxn)
  );

  int n_run = 0;
  int n_fail = 0;
  int lat_g = 0;
  logic [63:0] mem [logic [47:0]];

  // reference model state
  bit          pend = 1'b0;
  logic [1:0]  e_flt, e_lvl;
  logic [47:0] e_pa;
  logic [11:0] e_attr;
  string       e_tag = "";
  logic [47:0] exp_addr_q [$];

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] slot(logic [47:0] tbl, logic [47:0] va, int lvl);
    logic [47:0] ix;
    ix = (va >> (39 - 9*lvl)) & 48'h1FF;
    return {tbl[47:12], 12'h000} + ix * 8;
  endfunction

  function automatic logic [63:0] mk_tbl(logic [47:0] nxt, logic [4:0] lim);
    return {lim, 11'd0, nxt[47:12], 12'h003};
  endfunction

  // attr: idx[11:9] ns[8] ap[7:6] sh[5:4] ng[3] contig[2] pxn[1] uxn[0]
  function automatic logic [63:0] mk_leaf(logic [47:0] oa, logic [11:0] a, bit af, int lvl);
    logic [63:0] d;
    d = '0;
    d[47:12] = oa[47:12];
    d[4:2] = a[11:9];
    d[5]   = a[8];
    d[7:6] = a[7:6];
    d[9:8] = a[5:4];
    d[11]  = a[3];
    d[52]  = a[2];
    d[53]  = a[1];
    d[54]  = a[0];
    d[10]  = af;
    d[1:0] = (lvl == 3) ? 2'b11 : 2'b01;
    return d;
  endfunction

  task automatic ref_walk(input logic [47:0] va, input logic [47:0] base, input bit hd);
    logic [47:0] tbl, a, mask;
    logic [63:0] d;
    logic [4:0]  acc, lim;
    tbl = base; acc = '0;
    e_flt = 2'd0; e_pa = '0; e_attr = '0; e_lvl = 2'd0;
    exp_addr_q.delete();
    for (int lvl = 0; lvl < 4; lvl++) begin
      a = slot(tbl, va, lvl);
      exp_addr_q.push_back(a);
      d = mem.exists(a) ? mem[a] : 64'd0;
      e_lvl = 2'(lvl);
      if (!d[0]) begin e_flt = 2'd1; break; end
      if (d[1] && lvl < 3) begin
        lim = d[63:59];
        if (hd) lim[3:0] = 4'd0;
        acc = acc | lim;
        tbl = {d[47:12], 12'h000};
        continue;
      end
      if (lvl == 0 || (lvl == 3 && !d[1])) e_flt = 2'd1;
      else if (!d[10]) e_flt = 2'd2;
      else begin
        mask = (48'h1 << (12 + 9*(3-lvl))) - 48'h1;
        e_pa = (d[47:0] & ~mask) | (va & mask);
        e_attr = {d[4:2], d[5] | acc[4], d[7] | acc[3], d[6] & ~acc[2],
                  d[9:8], d[11], d[52], d[53] | acc[0], d[54] | acc[1]};
      end
      break;
    end
  endtask

  // memory responder
  int cnt = 0;
  logic [47:0] raddr;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem.exists(raddr) ? mem[raddr] : 64'd0;
      end
    end
    if (rst_n && mem_req_valid) begin
      cnt = lat_g + 1;
      raddr = mem_req_addr;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid) begin
        if (exp_addr_q.size() == 0) chk(e_tag, "R2 unexpected read", {16'd0, mem_req_addr}, 64'hFFFF_FFFF_FFFF_FFFF);
        else chk(e_tag, "R2 R3 read address", {16'd0, mem_req_addr}, {16'd0, exp_addr_q.pop_front()});
      end
      if (walk_done) begin
        if (!pend) chk(e_tag, "R12 spurious done", 64'd1, 64'd0);
        else begin
          chk(e_tag, "fault kind (R4 R5 R8)", {62'd0, walk_fault}, {62'd0, e_flt});
          chk(e_tag, "level (R4 R5 R8)", {62'd0, walk_level}, {62'd0, e_lvl});
          chk(e_tag, "R6 R12 pa", {16'd0, walk_pa}, {16'd0, e_pa});
          chk(e_tag, "R7 R9 R10 R11 attrs",
              {52'd0, walk_attr_idx, walk_ns, walk_ap, walk_sh, walk_ng, walk_contig, walk_pxn, walk_uxn},
              {52'd0, e_attr});
          chk(e_tag, "R2 reads left", 64'(exp_addr_q.size()), 64'd0);
          pend = 1'b0;
        end
      end
      chk(e_tag, "R1 ready", {63'd0, req_ready}, {63'd0, !pend});
    end
  end

  task automatic walk(input logic [47:0] va, input logic [47:0] base, input bit hd,
                      input int lat, input string tag);
    int k;
    @(negedge clk);
    lat_g = lat; req_va = va; req_base = base; req_hier_dis = hd; req_valid = 1'b1;
    @(posedge clk);
    ref_walk(va, base, hd);
    e_tag = tag;
    pend = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (pend && k < 500) begin @(negedge clk); k++; end
    if (pend) begin chk(tag, "R12 walk timeout", 64'd0, 64'd1); pend = 1'b0; end
    repeat (2) @(negedge clk);
  endtask

  task automatic path3(input logic [47:0] va, input logic [4:0] l0, input logic [4:0] l1,
                       input logic [4:0] l2);
    mem[slot(T0, va, 0)] = mk_tbl(T1, l0);
    mem[slot(T1, va, 1)] = mk_tbl(T2, l1);
    mem[slot(T2, va, 2)] = mk_tbl(T3, l2);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL R12 watchdog: got running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] va;
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_base = '0; req_hier_dis = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset", "R1 ready", {63'd0, req_ready}, 64'd1);
    chk("reset", "R12 done", {63'd0, walk_done}, 64'd0);
    chk("reset", "R2 read strobe", {63'd0, mem_req_valid}, 64'd0);

    // four-level walk to a page
    va = 48'h1234_5678_9ABC;
    mem.delete(); path3(va, 5'd0, 5'd0, 5'd0);
    mem[slot(T3, va, 3)] = mk_leaf(48'h0000_ABCD_E000, 12'hB5D, 1'b1, 3);
    walk(va, T0, 1'b0, 0, "R3 R6 R7 page");

    // level-1 block
    va = 48'h007F_C123_4567;
    mem.delete();
    mem[slot(T0, va, 0)] = mk_tbl(T1, 5'd0);
    mem[slot(T1, va, 1)] = mk_leaf(48'h0080_4000_0000, 12'h3A6, 1'b1, 1);
    walk(va, T0, 1'b0, 2, "R6 R7 1G block");

    // level-2 block with read-only at L0, no-user and XN at L1
    va = 48'hA5A5_A5A5_A5A5;
    mem.delete();
    mem[slot(T0, va, 0)] = mk_tbl(T1, 5'b01000);
    mem[slot(T1, va, 1)] = mk_tbl(T2, 5'b00110);
    mem[slot(T2, va, 2)] = mk_leaf(48'h0012_3460_0000, 12'h440, 1'b1, 2);
    walk(va, T0, 1'b0, 1, "R9 R10 limits");
    walk(va, T0, 1'b1, 1, "R11 limits off");

    // NS, read-only and PXN from L0, page at L3
    va = 48'h0F0F_0F0F_0F0F;
    mem.delete(); path3(va, 5'b11001, 5'd0, 5'd0);
    mem[slot(T3, va, 3)] = mk_leaf(48'h0000_0123_4000, 12'h040, 1'b1, 3);
    walk(va, T0, 1'b0, 0, "R9 R10 ns pxn");
    walk(va, T0, 1'b1, 3, "R11 R10 ns kept");

    // invalid at level 2
    va = 48'h0000_4020_1000;
    mem.delete();
    mem[slot(T0, va, 0)] = mk_tbl(T1, 5'd0);
    mem[slot(T1, va, 1)] = mk_tbl(T2, 5'd0);
    walk(va, T0, 1'b0, 3, "R4 invalid L2");

    // invalid at level 0
    mem.delete();
    walk(48'hFFFF_FFFF_F000, T0, 1'b0, 0, "R4 invalid L0");

    // reserved encoding at level 3
    va = 48'h3333_2222_1111;
    mem.delete(); path3(va, 5'd0, 5'd0, 5'd0);
    mem[slot(T3, va, 3)] = mk_leaf(48'h0000_0555_5000, 12'hFFF, 1'b1, 2);
    walk(va, T0, 1'b0, 1, "R4 reserved L3");

    // block at level 0
    va = 48'h8000_0000_0000;
    mem.delete();
    mem[slot(T0, va, 0)] = mk_leaf(48'h8000_0000_0000, 12'h0C0, 1'b1, 1);
    walk(va, T0, 1'b0, 0, "R5 L0 block");

    // access flag clear on a page
    va = 48'h0000_0000_2345;
    mem.delete(); path3(va, 5'd0, 5'd0, 5'd0);
    mem[slot(T3, va, 3)] = mk_leaf(48'h0000_0777_7000, 12'h0C0, 1'b0, 3);
    walk(va, T0, 1'b0, 2, "R8 access flag");

    // access flag clear on a level-2 block
    va = 48'h0000_4020_1000;
    mem.delete();
    mem[slot(T0, va, 0)] = mk_tbl(T1, 5'd0);
    mem[slot(T1, va, 1)] = mk_tbl(T2, 5'd0);
    mem[slot(T2, va, 2)] = mk_leaf(48'h0000_0020_0000, 12'h0C0, 1'b0, 2);
    walk(va, T0, 1'b0, 0, "R8 af block");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule